// File: doc/BRIEF.md
# Bit-Sliced Lookup Table with Early-Exit Search

This block is a small associative lookup. It holds 32 keys of 16 bits each and answers the question "which entry, if any, holds this key". The keys are not kept in 32 parallel registers with 32 full-width comparators. The table is stored transposed in a memory four words deep and 128 bits wide. Each memory word carries one 4-bit nibble of every entry, so one read returns the same nibble position for the whole table.

A search reads the words one per cycle, starting with the least significant nibble. A 32-bit set of surviving candidates starts as the set of valid entries. Each cycle it is narrowed to the entries whose nibble equals the matching nibble of the key. As soon as the set is empty, the search ends with a miss and the remaining words are not read. A hit is only possible once all four nibbles have agreed. When several entries survive, the lowest-numbered one is reported.

Entries are loaded or invalidated one at a time through a write port. A load rewrites the entry's nibble in all four words in one cycle. The write port is closed while a search is in progress.

Top module: `slice_cam`

## Requirements
- R1: After reset, busy, done, hit and hit_idx are all 0 and every entry is invalid, so any search misses.
- R2: A cycle with wr_en=1 and wr_inval=0 that is accepted stores wr_key in entry wr_idx and marks that entry valid. Nibble k of the entry is wr_key bits [4k+3:4k], and it is held in memory word k.
- R3: A cycle with wr_en=1 and wr_inval=1 that is accepted marks entry wr_idx invalid. An invalid entry never matches.
- R4: Nibbles are examined from bits [3:0] upward. If the candidate set first becomes empty at nibble k (k = 0..3), done rises after the (k+2)-th rising edge, counting the edge that samples srch_start as the first. In that cycle hit=0 and hit_idx=0.
- R5: A hit is declared only after all four nibbles match. done rises after the fifth rising edge counting the start edge, with hit=1.
- R6: When several valid entries hold the searched key, hit_idx is the lowest such index.
- R7: done is high for exactly one cycle. busy is high from the start edge until done rises, and it is low in the cycle where done is high.
- R8: hit and hit_idx keep their values after done falls, until the next search ends.
- R9: A write is refused while busy is high, and also in a cycle where srch_start is high. A refused write changes neither keys nor valid bits.
- R10: The key is captured on the start edge. srch_start and srch_key are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write request for one entry |
| wr_inval | input | 1 | With wr_en: 1 invalidates the entry, 0 loads wr_key |
| wr_idx | input | 5 | Entry index to write |
| wr_key | input | 16 | Key value to load |
| srch_start | input | 1 | Starts a search when the block is idle |
| srch_key | input | 16 | Key to search for, sampled with srch_start |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse that marks a valid result |
| hit | output | 1 | The last search found a match |
| hit_idx | output | 5 | Index of the lowest matching entry |

## Verification
The bench keeps its own copy of the table. For every search it works out the nibble at which the candidate set empties, and so the exact cycle of done. A design that read the nibbles in the wrong order, or did not exit early, would report done on the wrong edge. Searches use keys with one bit flipped in each of the 16 positions, so misses occur at every nibble depth. Duplicate keys test the priority rule: choosing the highest index would show up at once. Further cases write during a search, or in the same cycle as start, and restart a search while one is running. A design that let these through would later hit on a key that was never accepted, or report a result for the wrong key.

// File: rtl/slice_cam_pkg.sv
package slice_cam_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_st_e;
endpackage

// File: rtl/slice_cam_mem.sv
// Transposed key store: word k holds nibble k of every entry.
module slice_cam_mem #(
  parameter int ENTRIES = 32,
  parameter int SLICE_W = 4,
  parameter int NSLICE  = 4,
  localparam int ROW_W  = ENTRIES * SLICE_W,
  localparam int AW     = $clog2(NSLICE),
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [NSLICE*SLICE_W-1:0] wr_word,
  input  logic                      rd_en,
  input  logic [AW-1:0]             rd_addr,
  output logic [ROW_W-1:0]          rd_row
);
  logic [ROW_W-1:0] rows_w [NSLICE];
  logic [ROW_W-1:0] rd_row_q;

  for (genvar k = 0; k < NSLICE; k++) begin : g_word
    logic [ROW_W-1:0] row_q;
    // Per-field write enable: only entry wr_idx's nibble changes.
    always_ff @(posedge clk) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_en && (wr_idx == IW'(e))) begin
          row_q[e*SLICE_W +: SLICE_W] <= wr_word[k*SLICE_W +: SLICE_W];
        end
      end
    end
    assign rows_w[k] = row_q;
  end

  // One-cycle synchronous read.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_row_q <= rows_w[rd_addr];
    end
  end

  assign rd_row = rd_row_q;
endmodule

// File: rtl/slice_cam_match.sv
// Nibble compare across all entries, candidate narrowing, lowest-index pick.
module slice_cam_match #(
  parameter int ENTRIES = 32,
  parameter int SLICE_W = 4,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES*SLICE_W-1:0] row,
  input  logic [SLICE_W-1:0]         key_nib,
  input  logic [ENTRIES-1:0]         cand_in,
  output logic [ENTRIES-1:0]         cand_out,
  output logic                       any_left,
  output logic [IW-1:0]              first_idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign eq[e] = (row[e*SLICE_W +: SLICE_W] == key_nib);
  end

  assign cand_out = cand_in & eq;
  assign any_left = |cand_out;

  always_comb begin
    first_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (cand_out[e]) first_idx = IW'(e);
    end
  end

  // R6: the chosen index is itself a surviving candidate.
  always_comb begin
    if (any_left) begin
      assert_pick_is_cand_R6: assert (cand_out[first_idx]);
    end
  end
endmodule

// File: rtl/slice_cam.sv
module slice_cam
  import slice_cam_pkg::*;
#(
  parameter int ENTRIES  = 32,
  parameter int KEY_W    = 16,
  parameter int SLICE_W  = 4,
  localparam int NSLICE  = KEY_W / SLICE_W,
  localparam int AW      = $clog2(NSLICE),
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int ROW_W   = ENTRIES * SLICE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_inval,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             srch_start,
  input  logic [KEY_W-1:0] srch_key,
  output logic             busy,
  output logic             done,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  scan_st_e           st_q, st_d;
  logic [AW-1:0]      slice_q, slice_d;
  logic [KEY_W-1:0]   key_q, key_d;
  logic [ENTRIES-1:0] cand_q, cand_d;
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic               done_q, done_d;
  logic               hit_q, hit_d;
  logic [IDX_W-1:0]   idx_q, idx_d;

  logic               scanning, accept_start, wr_ok, last_slice;
  logic               rd_en;
  logic [AW-1:0]      rd_addr;
  logic [ROW_W-1:0]   rd_row;
  logic [SLICE_W-1:0] key_nib;
  logic [ENTRIES-1:0] cand_nxt;
  logic               any_left;
  logic [IDX_W-1:0]   first_idx;

  assign scanning     = (st_q == ST_SCAN);
  assign accept_start = !scanning && srch_start;
  assign wr_ok        = wr_en && !scanning && !srch_start;
  assign last_slice   = (slice_q == AW'(NSLICE - 1));
  assign key_nib      = key_q[slice_q*SLICE_W +: SLICE_W];

  // Next word is fetched one cycle ahead of its evaluation.
  assign rd_en   = accept_start || (scanning && any_left && !last_slice);
  assign rd_addr = accept_start ? '0 : AW'(slice_q + 1'b1);

  slice_cam_mem #(
    .ENTRIES (ENTRIES),
    .SLICE_W (SLICE_W),
    .NSLICE  (NSLICE)
  ) mem_i (
    .clk     (clk),
    .wr_en   (wr_ok && !wr_inval),
    .wr_idx  (wr_idx),
    .wr_word (wr_key),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_row  (rd_row)
  );

  slice_cam_match #(
    .ENTRIES (ENTRIES),
    .SLICE_W (SLICE_W)
  ) match_i (
    .row       (rd_row),
    .key_nib   (key_nib),
    .cand_in   (cand_q),
    .cand_out  (cand_nxt),
    .any_left  (any_left),
    .first_idx (first_idx)
  );

  always_comb begin
    st_d    = st_q;
    slice_d = slice_q;
    key_d   = key_q;
    cand_d  = cand_q;
    valid_d = valid_q;
    done_d  = 1'b0;
    hit_d   = hit_q;
    idx_d   = idx_q;

    if (accept_start) begin
      st_d    = ST_SCAN;
      slice_d = '0;
      key_d   = srch_key;
      cand_d  = valid_q;
    end

    if (scanning) begin
      cand_d = cand_nxt;
      if (!any_left) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        hit_d  = 1'b0;
        idx_d  = '0;
      end else if (last_slice) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        hit_d  = 1'b1;
        idx_d  = first_idx;
      end else begin
        slice_d = AW'(slice_q + 1'b1);
      end
    end

    if (wr_ok) begin
      valid_d[wr_idx] = !wr_inval;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= ST_IDLE;
      slice_q <= '0;
      key_q   <= '0;
      cand_q  <= '0;
      valid_q <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      st_q    <= st_d;
      slice_q <= slice_d;
      key_q   <= key_d;
      cand_q  <= cand_d;
      valid_q <= valid_d;
      done_q  <= done_d;
      hit_q   <= hit_d;
      idx_q   <= idx_d;
    end
  end

  assign busy    = scanning;
  assign done    = done_q;
  assign hit     = hit_q;
  assign hit_idx = idx_q;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  assert_busy_ends_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(busy) |-> done);

  assert_early_miss_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && !any_left) |=> (done && !hit));

  assert_hit_on_valid_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && hit) |-> valid_q[hit_idx]);

  assert_no_write_busy_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> $stable(valid_q));

  assert_key_held_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && !done) |=> $stable(key_q));
endmodule

// File: tb/slice_cam_tb.sv
module slice_cam_tb_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_inval;
  logic [4:0]  wr_idx;
  logic [15:0] wr_key;
  logic        srch_start;
  logic [15:0] srch_key;
  logic        busy, done, hit;
  logic [4:0]  hit_idx;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [15:0] mk [N];
  logic [N-1:0] mv;

  always #2.5 clk = ~clk;

  slice_cam dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_inval(wr_inval),
    .wr_idx(wr_idx), .wr_key(wr_key), .srch_start(srch_start),
    .srch_key(srch_key), .busy(busy), .done(done), .hit(hit),
    .hit_idx(hit_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] key_of(input int e);
    return {4'(e * 7 + 3), 4'(e / 2), 4'(e % 4), 4'(e % 3)};
  endfunction

  // Expected edge count to done, hit and index, from the table copy.
  task automatic predict(input logic [15:0] k, output int cyc, output bit h, output int idx);
    logic [N-1:0] cand;
    cand = mv;
    cyc = 5; h = 1'b1; idx = 0;
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < N; e++) begin
        if (mk[e][s*4 +: 4] != k[s*4 +: 4]) cand[e] = 1'b0;
      end
      if (cand == '0) begin
        cyc = s + 2; h = 1'b0; idx = 0;
        return;
      end
    end
    for (int e = N - 1; e >= 0; e--) if (cand[e]) idx = e;
  endtask

  task automatic do_write(input int e, input logic [15:0] k, input bit inval);
    @(negedge clk);
    wr_en = 1'b1; wr_inval = inval; wr_idx = 5'(e); wr_key = k;
    @(negedge clk);
    wr_en = 1'b0; wr_inval = 1'b0;
    if (inval) mv[e] = 1'b0;
    else begin mk[e] = k; mv[e] = 1'b1; end
  endtask

  // side: 0 none, 1 write during busy, 2 restart during busy, 3 write with start
  task automatic do_search(input logic [15:0] k, input int side, input string req);
    int cyc, ecyc, eidx;
    bit eh;
    predict(k, ecyc, eh, eidx);
    @(negedge clk);
    srch_start = 1'b1; srch_key = k;
    if (side == 3) begin
      wr_en = 1'b1; wr_inval = 1'b0; wr_idx = 5'd9; wr_key = 16'hBEEF;
    end
    @(negedge clk);
    srch_start = 1'b0; wr_en = 1'b0;
    cyc = 1;
    chk(busy === 1'b1, "R7 busy after start", int'(busy), 1);
    if (side == 1) begin
      wr_en = 1'b1; wr_inval = 1'b0; wr_idx = 5'd7; wr_key = 16'hCAFE;
    end
    if (side == 2) begin
      srch_start = 1'b1; srch_key = ~k;
    end
    while (!done && cyc < 12) begin
      @(negedge clk);
      wr_en = 1'b0; srch_start = 1'b0;
      cyc++;
      if (!done) chk(busy === 1'b1, "R7 busy held", int'(busy), 1);
    end
    chk(cyc == ecyc, {req, " R4/R5 done edge"}, cyc, ecyc);
    chk(busy === 1'b0, "R7 busy low with done", int'(busy), 0);
    chk(hit === eh, {req, " hit"}, int'(hit), int'(eh));
    chk(int'(hit_idx) == eidx, {req, " R6 index"}, int'(hit_idx), eidx);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", int'(done), 0);
    chk(hit === eh && int'(hit_idx) == eidx, "R8 result held", int'(hit_idx), eidx);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_inval = 0; wr_idx = 0; wr_key = 0;
    srch_start = 0; srch_key = 0; mv = '0;
    for (int e = 0; e < N; e++) mk[e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && hit === 0 && hit_idx === 0,
        "R1 reset outputs", int'({busy, done, hit}), 0);
    do_search(16'h0000, 0, "R1 empty table");
    do_search(16'h1234, 0, "R1 empty table");

    for (int e = 0; e < N; e++) do_write(e, key_of(e), 1'b0);

    // R2/R4/R5: every stored key, then every single-bit variant
    for (int e = 0; e < N; e++) begin
      do_search(key_of(e), 0, "R2 stored key");
      for (int b = 0; b < 16; b++) do_search(key_of(e) ^ (16'h1 << b), 0, "R4 flipped bit");
    end

    // R6: duplicate keys, lowest wins
    do_write(20, key_of(5), 1'b0);
    do_write(30, key_of(5), 1'b0);
    do_search(key_of(5), 0, "R6 duplicates");
    do_write(5, 16'h0, 1'b1);
    do_search(key_of(5), 0, "R3 R6 after invalidate");
    do_write(20, 16'h0, 1'b1);
    do_write(30, 16'h0, 1'b1);
    do_search(key_of(5), 0, "R3 all copies invalid");

    // R2: overwrite with a fresh key
    do_write(12, 16'h9E3F, 1'b0);
    do_search(16'h9E3F, 0, "R2 overwrite new");
    do_search(key_of(12), 0, "R2 overwrite old");

    // R9: writes refused during busy and alongside start
    do_search(key_of(3), 1, "R9 write in busy");
    do_search(16'hCAFE, 0, "R9 refused busy write");
    do_search(key_of(7), 0, "R9 old key kept");
    do_search(key_of(4), 3, "R9 write with start");
    do_search(16'hBEEF, 0, "R9 refused start write");
    do_search(key_of(9), 0, "R9 old key kept");

    // R10: restart ignored while busy
    do_search(key_of(10), 2, "R10 restart ignored");
    do_search(key_of(10) ^ 16'h4000, 2, "R10 restart ignored miss");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule